// File: doc/BRIEF.md
# Strided Vector Bank Scheduler

This block walks through the elements of one strided vector access and sends one element address per cycle into a memory of 16 interleaved banks. Element i lives at the base address plus i times a signed stride. The low four bits of the word address select the bank, and the remaining upper bits are the word offset inside that bank. After a bank is accessed, it cannot take another access for four cycles. The scheduler keeps a small down-counter for each bank. It holds issue whenever the next element would land on a bank that is still recovering. It never skips ahead to a later element, so requests always leave in element order.

The memory answers every request after a fixed delay, so answers come back in the order of the requests. The block numbers each returned word with its element index and passes it on as an ordered output stream. One cycle after the last element has come back, it raises a single-cycle completion pulse.

Strides that share no factor with 16 spread over all banks and run at one element per cycle. Stride 4 touches four banks and still keeps up. Stride 8 falls to half rate. Strides of 0 or 16 hit a single bank and run at one element every four cycles.

Top module: `vec_stride_sched`

## Requirements
- R1: Request k of a run carries word address (base + k*stride) mod 2^16. The bank index is bits [3:0] of that address and the offset is bits [15:4].
- R2: Requests leave in increasing element order with at most one per cycle. No element is skipped or repeated, and a run of length n makes exactly n requests.
- R3: A bank that receives a request at cycle t receives no other request at cycles t+1, t+2 or t+3.
- R4: Issue is never held back when the next element's bank is free. A stride whose bank pattern covers four or more banks issues n elements in n consecutive cycles, starting the cycle after the start pulse is taken. This covers strides coprime to 16, negative strides and stride 4.
- R5: A stride covering d < 4 distinct banks issues element k at cycle offset 4*(k div d) + (k mod d) from the first request. Stride 8 gives d = 2. Strides 0 and 16 give d = 1.
- R6: Each word returned on rsp_valid during a run appears on out_valid in the same cycle, with its data unchanged. out_idx counts 0, 1, 2, ... in return order.
- R7: done is high for exactly one cycle, the cycle after the last element returns. busy drops in the cycle after done.
- R8: A start pulse while busy is high is ignored. The run in progress keeps its base, stride and length.
- R9: A vector length above 64 is treated as 64. A length of 0 makes no requests and raises done in the cycle after the start pulse.
- R10: After reset, busy, done, req_valid and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; taken only while idle |
| base | input | 16 | Word address of element 0 |
| stride | input | 16 | Signed element stride in words (two's complement) |
| vlen | input | 7 | Element count, clamped to 64 |
| req_valid | output | 1 | A bank request is issued this cycle |
| req_bank | output | 4 | Bank index of the request |
| req_offset | output | 12 | Word offset within the bank |
| rsp_valid | input | 1 | Memory returns a word this cycle |
| rsp_data | input | 32 | Returned word |
| out_valid | output | 1 | Element output valid |
| out_idx | output | 6 | Element index of out_data |
| out_data | output | 32 | Element data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the exact pattern of stalls. It only shows up when the stride revisits a bank sooner than the bank's recovery time, and it has to be measured cycle by cycle against the first request. The bench records the cycle of every request and compares it with a closed-form schedule built from the number of distinct banks the stride touches. It covers strides 1, 4, 8, 16, 0 and a negative coprime stride, so full-rate, half-rate and quarter-rate patterns all appear. A second start pulse is injected in the middle of a run, and a zero-length run is issued, to reach the control corners.

// File: rtl/vec_stride_sched.sv
module vec_stride_sched #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int NBANK  = 16,
  parameter int BUSY   = 4,
  parameter int MAXLEN = 64,
  localparam int BW = $clog2(NBANK),
  localparam int LW = $clog2(MAXLEN + 1),
  localparam int IW = $clog2(MAXLEN),
  localparam int TW = (BUSY > 1) ? $clog2(BUSY) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic [LW-1:0] vlen,
  output logic          req_valid,
  output logic [BW-1:0] req_bank,
  output logic [AW-BW-1:0] req_offset,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          out_valid,
  output logic [IW-1:0] out_idx,
  output logic [DW-1:0] out_data,
  output logic          busy,
  output logic          done
);

  logic          active;
  logic [AW-1:0] cur_addr, stride_q;
  logic [LW-1:0] len_q, iss_cnt, ret_cnt;
  logic [TW-1:0] tmr [NBANK];
  logic [NBANK-1:0] bank_free;

  wire [LW-1:0] len_d = (vlen > LW'(MAXLEN)) ? LW'(MAXLEN) : vlen;

  assign req_bank   = cur_addr[BW-1:0];
  assign req_offset = cur_addr[AW-1:BW];
  assign req_valid  = active && (iss_cnt < len_q) && bank_free[req_bank];
  assign out_valid  = active && rsp_valid && (ret_cnt < len_q);
  assign out_idx    = ret_cnt[IW-1:0];
  assign out_data   = rsp_data;
  assign busy       = active;
  assign done       = active && (ret_cnt == len_q) && (iss_cnt == len_q);

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      assign bank_free[b] = (tmr[b] == '0);
      always_ff @(posedge clk) begin
        if (!rst_n)
          tmr[b] <= '0;
        else if (req_valid && req_bank == BW'(b))
          tmr[b] <= TW'(BUSY - 1);
        else if (tmr[b] != '0)
          tmr[b] <= tmr[b] - 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_addr <= '0;
      stride_q <= '0;
      len_q    <= '0;
      iss_cnt  <= '0;
      ret_cnt  <= '0;
    end else if (!active) begin
      if (start) begin
        active   <= 1'b1;
        cur_addr <= base;
        stride_q <= stride;
        len_q    <= len_d;
        iss_cnt  <= '0;
        ret_cnt  <= '0;
      end
    end else if (done) begin
      active <= 1'b0;
    end else begin
      if (req_valid) begin
        cur_addr <= cur_addr + stride_q;
        iss_cnt  <= iss_cnt + 1'b1;
      end
      if (out_valid)
        ret_cnt <= ret_cnt + 1'b1;
    end
  end

  generate
    for (genvar k = 1; k < BUSY; k++) begin : g_gap
      p_bank_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid, k) |-> $past(req_bank, k) != req_bank);
    end
  endgenerate

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && $past(req_valid) |->
      {req_offset, req_bank} == $past({req_offset, req_bank}) + stride_q);

  p_idx_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> out_idx == $past(out_idx) + 1'b1);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && start |=> $stable(len_q) && $stable(stride_q));

  p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> len_q <= LW'(MAXLEN));

endmodule

// File: tb/vec_stride_sched_tb_top.sv
module vec_stride_sched_tb_top;
  localparam int LAT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] base = '0, stride = '0;
  logic [6:0]  vlen = '0;
  logic        req_valid, rsp_valid, out_valid, busy, done;
  logic [3:0]  req_bank;
  logic [11:0] req_offset;
  logic [31:0] rsp_data, out_data;
  logic [5:0]  out_idx;

  always #10 clk = ~clk;

  vec_stride_sched dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
    .vlen(vlen), .req_valid(req_valid), .req_bank(req_bank),
    .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data),
    .busy(busy), .done(done));

  // fixed-latency memory model
  logic        pv [LAT];
  logic [15:0] pa [LAT];
  always @(posedge clk) begin
    pv[0] <= req_valid;
    pa[0] <= {req_offset, req_bank};
    for (int i = 1; i < LAT; i++) begin
      pv[i] <= pv[i-1];
      pa[i] <= pa[i-1];
    end
  end
  assign rsp_valid = (pv[LAT-1] === 1'b1);
  assign rsp_data  = {pa[LAT-1], ~pa[LAT-1]};

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_req, n_out, done_cnt, done_cyc, last_out_cyc;
  int req_cyc [64];
  logic [15:0] req_adr [64];
  logic [15:0] exp_base, exp_stride;

  function automatic logic [31:0] mem_word(logic [15:0] a);
    return {a, ~a};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (req_valid) begin
        if (n_req < 64) begin
          req_cyc[n_req] = cyc;
          req_adr[n_req] = {req_offset, req_bank};
        end
        n_req++;
      end
      if (out_valid) begin
        logic [15:0] ea;
        ea = exp_base + 16'(n_out) * exp_stride;
        chk(out_idx == 6'(n_out), "R6 out_idx", out_idx, n_out);
        chk(out_data == mem_word(ea), "R6 out_data", out_data, mem_word(ea));
        n_out++;
        last_out_cyc = cyc;
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  function automatic int banks_touched(logic [15:0] s);
    int a, b, t;
    a = int'(s[3:0]);
    if (a == 0) return 1;
    b = 16;
    while (a != 0) begin t = b % a; b = a; a = t; end
    return 16 / b;
  endfunction

  task automatic clear_run(input logic [15:0] b, input logic [15:0] s);
    n_req = 0; n_out = 0; done_cnt = 0; done_cyc = -1; last_out_cyc = -1;
    exp_base = b; exp_stride = s;
  endtask

  task automatic launch(input logic [15:0] b, input logic [15:0] s,
                        input logic [6:0] n, output int scyc);
    @(negedge clk);
    base = b; stride = s; vlen = n; start = 1'b1; scyc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((busy || done_cnt == 0) && t < 3000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_run(input string tag, input int exp_n, input int scyc);
    int d, bad_a, bad_t, eo;
    logic [15:0] ea;
    chk(n_req == exp_n, {tag, " R2 request count"}, n_req, exp_n);
    chk(n_out == exp_n, {tag, " R6 return count"}, n_out, exp_n);
    d = banks_touched(exp_stride);
    bad_a = 0; bad_t = 0;
    for (int k = 0; k < exp_n && k < n_req && k < 64; k++) begin
      ea = exp_base + 16'(k) * exp_stride;
      if (req_adr[k] != ea) bad_a++;
      eo = (d >= 4) ? k : 4 * (k / d) + (k % d);
      if (req_cyc[k] - req_cyc[0] != eo) bad_t++;
    end
    chk(bad_a == 0, {tag, " R1 element addresses"}, bad_a, 0);
    chk(bad_t == 0, {tag, (d >= 4) ? " R4 issue timing" : " R5 stall timing"}, bad_t, 0);
    if (exp_n > 0)
      chk(req_cyc[0] == scyc + 1, {tag, " R4 first issue"}, req_cyc[0], scyc + 1);
    chk(done_cnt == 1, {tag, " R7 done pulses"}, done_cnt, 1);
    if (exp_n > 0)
      chk(done_cyc == last_out_cyc + 1, {tag, " R7 done cycle"}, done_cyc, last_out_cyc + 1);
    else
      chk(done_cyc == scyc + 1, {tag, " R9 empty done cycle"}, done_cyc, scyc + 1);
    chk(!busy, {tag, " R7 idle after done"}, busy, 0);
  endtask

  task automatic t_run(input string tag, input logic [15:0] b, input logic [15:0] s,
                       input logic [6:0] n, input int exp_n);
    int sc;
    clear_run(b, s);
    launch(b, s, n, sc);
    wait_idle();
    check_run(tag, exp_n, sc);
  endtask

  task automatic t_start_busy();
    int sc;
    clear_run(16'h0040, 16'd1);
    launch(16'h0040, 16'd1, 7'd10, sc);
    repeat (3) @(negedge clk);
    base = 16'h0500; stride = 16'd2; vlen = 7'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    check_run("start_busy R8", 10, sc);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    clear_run(16'h0, 16'h0);
    repeat (5) @(negedge clk);
    chk(!busy && !done && !req_valid && !out_valid, "R10 reset state",
        {busy, done, req_valid, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req_valid, "R10 idle after reset", {busy, req_valid}, 0);
    t_run("unit stride R4",     16'h0100, 16'd1,     7'd64, 64);
    t_run("stride 4 R4",        16'h0203, 16'd4,     7'd20, 20);
    t_run("stride -3 R4",       16'h0005, 16'hFFFD,  7'd17, 17);
    t_run("stride 8 R5",        16'h0003, 16'd8,     7'd16, 16);
    t_run("stride 0 R5",        16'h1234, 16'd0,     7'd8,  8);
    t_run("stride 16 R5",       16'h0007, 16'd16,    7'd6,  6);
    t_run("length clamp R9",    16'h0010, 16'd5,     7'd100, 64);
    t_run("empty run R9",       16'h0010, 16'd1,     7'd0,  0);
    t_run("single element R2",  16'hFFFF, 16'd3,     7'd1,  1);
    t_start_busy();
    finish_up();
  end
endmodule